// File: doc/BRIEF.md
# Programmable Memory Attribute Region Checker

This block holds a small table of programmable memory regions and, for any physical address presented to its lookup port, reports the cacheability and bufferability class of the region that covers it. Each entry has a 64-bit address register that describes a naturally aligned power-of-two region. Each entry also has a configuration byte that carries an entry type and a memory-type code. The configuration bytes are packed eight to a 64-bit register. A CSR-style port with a bank selector, an index and a write strobe gives access to the address registers, the packed configuration registers and a read-only feature word.

Setup software writes each region as `(base >> 2) + (size >> 3) - 1`. The number of trailing ones in that value gives the region size. Setup software reads each address register back to confirm the write. The lookup port takes an address and returns, one cycle later, a hit flag, the index of the winning entry and its memory-type code. When no entry matches, it returns a default code set by a parameter.

Top module: `memattr_region_unit`

## Requirements
- R1: Each of the sixteen address registers (bank 1, indices 0 to 15) stores all 64 bits written to it and returns them unchanged on a read. A read returns data on `csr_rdata` one cycle after the bank and index are presented.
- R2: The configuration bytes sit in configuration bank 0. Entry n occupies bits [8*(n mod 8)+6 : 8*(n mod 8)] of the configuration register at index 2*(n div 8), which means index 0 for entries 0 to 7 and index 2 for entries 8 to 15. Every other index in bank 0 reads as zero, and writes to those indices change nothing.
- R3: A configuration byte keeps 7 bits, and its bit 7 always reads as zero. Bits [1:0] hold the entry type. Bits [6:2] hold the memory-type code.
- R4: An entry with entry type 3 is a power-of-two region. Let the entry's address register hold v, and let v have k trailing ones. The entry matches byte addresses from 4*(v - 2^k + 1) up to, but not including, that base plus 2^(k+3). For example, base 0x5800_0000 with size 0x0800_0000 is written as 0x16FF_FFFF.
- R5: An entry whose type is 0, 1 or 2 never matches, whatever its address register holds.
- R6: When several enabled entries match, the entry with the lowest index wins, and `lk_entry` reports that index.
- R7: When no entry matches, `lk_hit` is 0, `lk_entry` is 0 and `lk_mtype` equals the parameter `DEFAULT_MTYPE`.
- R8: On a hit, `lk_mtype` returns the winning entry's 5-bit code unchanged. The codes are 0 for device non-bufferable, 1 for device bufferable, 2 for non-cacheable non-bufferable, 3 for non-cacheable bufferable, 8 for write-back no-allocate, 9 for write-back read-allocate, 10 for write-back write-allocate and 11 for write-back read-and-write-allocate. Reserved codes such as 5 are also passed through unchanged.
- R9: A lookup presented with `lk_req` high at a clock edge produces its result, together with `lk_vld` high, in the following cycle. `lk_vld` is low in any cycle after an edge where `lk_req` was low.
- R10: Bank 2 reads a constant feature word whose only set bit is bit 30, which marks the unit as present. Bank 3 reads zero. Writes to banks 2 and 3 are ignored.
- R11: A synchronous active-high reset clears every address and configuration register, `csr_rdata`, `lk_vld`, `lk_hit` and `lk_entry`, and sets `lk_mtype` to `DEFAULT_MTYPE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_bank | input | 2 | Bank select: 0 configuration, 1 address, 2 feature, 3 none |
| csr_idx | input | 4 | Register index within the bank |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Registered read data for the selected bank and index |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | PA_W-2 | Lookup byte address bits [PA_W-1:2] |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An enabled region matched |
| lk_entry | output | 4 | Index of the winning entry |
| lk_mtype | output | 5 | Memory-type code of the winner, or the default code |

## Verification
On every cycle, the assertions check the following: the one-cycle request-to-valid relation, the default outputs on a miss, the contents of the feature bank and the empty bank, bit 7 of each configuration byte reading zero, the holes in bank 0, address register read-back after a write, and the reset state. Region decoding, the choice of winner among overlapping entries, the suppression of entries whose type is not 3, and the configuration-byte packing depend on the programmed table. Only the bench's scenarios can show these behaviours. The bench sweeps region edges and a strided address range against an arithmetic model of base and size.

// File: rtl/memattr_pkg.sv
package memattr_pkg;
  localparam int XLEN         = 64;
  localparam int BYTES_PER_CR = XLEN / 8;
  localparam int CFG_W        = 7;
  localparam int ET_W         = 2;
  localparam int MT_LSB       = ET_W;
  localparam int MT_W         = CFG_W - MT_LSB;
  localparam int FEAT_BIT     = 30;

  localparam logic [ET_W-1:0] ETYPE_NAPOT = 2'd3;

  typedef enum logic [1:0] {
    BANK_CFG  = 2'd0,
    BANK_ADDR = 2'd1,
    BANK_FEAT = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  typedef enum logic [MT_W-1:0] {
    MT_DEV_NB  = 5'd0,
    MT_DEV_B   = 5'd1,
    MT_NC_NB   = 5'd2,
    MT_NC_B    = 5'd3,
    MT_WB_NA   = 5'd8,
    MT_WB_RA   = 5'd9,
    MT_WB_WA   = 5'd10,
    MT_WB_RWA  = 5'd11
  } mtype_e;
endpackage

// File: rtl/memattr_regfile.sv
module memattr_regfile
  import memattr_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CFG_REGS = (NUM_ENTRIES + BYTES_PER_CR - 1) / BYTES_PER_CR
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [1:0]                            bank,
  input  logic [IDX_W-1:0]                      idx,
  input  logic                                  we,
  input  logic [XLEN-1:0]                       wdata,
  output logic [XLEN-1:0]                       rdata,
  output logic [NUM_ENTRIES-1:0][XLEN-1:0]      areg,
  output logic [NUM_ENTRIES-1:0][CFG_W-1:0]     cfg
);
  logic [XLEN-1:0] rd_next;

  // R1, R2, R3, R10: write decode; unimplemented targets fall through
  always_ff @(posedge clk) begin
    if (rst) begin
      areg <= '0;
      cfg  <= '0;
    end else if (we) begin
      case (bank_e'(bank))
        BANK_ADDR: begin
          if (int'(idx) < NUM_ENTRIES) areg[idx] <= wdata;
        end
        BANK_CFG: begin
          for (int r = 0; r < CFG_REGS; r++) begin
            if (int'(idx) == 2 * r) begin
              for (int b = 0; b < BYTES_PER_CR; b++) begin
                if (r * BYTES_PER_CR + b < NUM_ENTRIES)
                  cfg[r * BYTES_PER_CR + b] <= wdata[b*8 +: CFG_W];
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (bank_e'(bank))
      BANK_ADDR: begin
        if (int'(idx) < NUM_ENTRIES) rd_next = areg[idx];
      end
      BANK_CFG: begin
        for (int r = 0; r < CFG_REGS; r++) begin
          if (int'(idx) == 2 * r) begin
            for (int b = 0; b < BYTES_PER_CR; b++) begin
              if (r * BYTES_PER_CR + b < NUM_ENTRIES)
                rd_next[b*8 +: CFG_W] = cfg[r * BYTES_PER_CR + b];
            end
          end
        end
      end
      BANK_FEAT: rd_next[FEAT_BIT] = 1'b1;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/memattr_napot_match.sv
module memattr_napot_match
  import memattr_pkg::*;
#(
  parameter int PA_W = 34
) (
  input  logic [XLEN-1:0]   areg,
  input  logic [ET_W-1:0]   etype,
  input  logic [PA_W-1:2]   addr,
  output logic              hit
);
  logic [XLEN-1:0] waddr;
  logic [XLEN-1:0] span;

  assign waddr = XLEN'(addr);
  // span marks the trailing ones of areg plus the first zero above them
  assign span  = areg ^ (areg + XLEN'(1));
  assign hit   = (etype == ETYPE_NAPOT) && (((waddr ^ areg) & ~span) == '0);
endmodule

// File: rtl/memattr_prio_pick.sv
module memattr_prio_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] sel
);
  // R6: scan from the top so the lowest set index is assigned last
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) sel = IDX_W'(i);
    end
  end
  assign any = |hits;
endmodule

// File: rtl/memattr_region_unit.sv
module memattr_region_unit
  import memattr_pkg::*;
#(
  parameter int               NUM_ENTRIES   = 16,
  parameter int               PA_W          = 34,
  parameter logic [MT_W-1:0]  DEFAULT_MTYPE = 5'd0,
  localparam int              IDX_W         = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        csr_bank,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              lk_req,
  input  logic [PA_W-1:2]   lk_addr,
  output logic              lk_vld,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_entry,
  output logic [MT_W-1:0]   lk_mtype
);
  logic [NUM_ENTRIES-1:0][XLEN-1:0]  areg;
  logic [NUM_ENTRIES-1:0][CFG_W-1:0] cfg;
  logic [NUM_ENTRIES-1:0]            hits;
  logic                              any_hit;
  logic [IDX_W-1:0]                  win;
  logic [CFG_W-1:0]                  win_cfg;

  memattr_regfile #(.NUM_ENTRIES(NUM_ENTRIES)) regs_i (
    .clk(clk), .rst(rst), .bank(csr_bank), .idx(csr_idx), .we(csr_we),
    .wdata(csr_wdata), .rdata(csr_rdata), .areg(areg), .cfg(cfg)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    memattr_napot_match #(.PA_W(PA_W)) match_i (
      .areg(areg[g]), .etype(cfg[g][ET_W-1:0]), .addr(lk_addr), .hit(hits[g])
    );
  end

  memattr_prio_pick #(.N(NUM_ENTRIES)) pick_i (
    .hits(hits), .any(any_hit), .sel(win)
  );

  assign win_cfg = cfg[win];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vld   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_entry <= '0;
      lk_mtype <= DEFAULT_MTYPE;
    end else begin
      lk_vld   <= lk_req;
      lk_hit   <= any_hit;
      lk_entry <= any_hit ? win : '0;
      lk_mtype <= any_hit ? win_cfg[CFG_W-1:MT_LSB] : DEFAULT_MTYPE;
    end
  end
endmodule

// File: rtl/memattr_chk.sv
module memattr_chk
  import memattr_pkg::*;
#(
  parameter int               NUM_ENTRIES   = 16,
  parameter int               PA_W          = 34,
  parameter logic [MT_W-1:0]  DEFAULT_MTYPE = 5'd0,
  localparam int              IDX_W         = $clog2(NUM_ENTRIES)
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        csr_bank,
  input logic [IDX_W-1:0]  csr_idx,
  input logic              csr_we,
  input logic [XLEN-1:0]   csr_wdata,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              lk_req,
  input logic              lk_vld,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_entry,
  input logic [MT_W-1:0]   lk_mtype
);
  localparam logic [XLEN-1:0] BIT7_MASK = 64'h8080_8080_8080_8080;
  localparam logic [XLEN-1:0] FEAT_WORD = XLEN'(1) << FEAT_BIT;

  assert_addr_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_bank == 2'd1) ##1 (!csr_we && csr_bank == 2'd1 && csr_idx == $past(csr_idx))
    |=> csr_rdata == $past(csr_wdata, 2));

  assert_cfg_hole_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_bank == 2'd0 && csr_idx[0]) |=> csr_rdata == '0);

  assert_cfg_bit7_R3: assert property (@(posedge clk) disable iff (rst)
    csr_bank == 2'd0 |=> (csr_rdata & BIT7_MASK) == '0);

  assert_miss_default_R7: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_mtype == DEFAULT_MTYPE && lk_entry == '0));

  assert_req_valid_R9: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_vld);

  assert_idle_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_vld);

  assert_feature_word_R10: assert property (@(posedge clk) disable iff (rst)
    csr_bank == 2'd2 |=> csr_rdata == FEAT_WORD);

  assert_empty_bank_R10: assert property (@(posedge clk) disable iff (rst)
    csr_bank == 2'd3 |=> csr_rdata == '0);

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (csr_rdata == '0 && !lk_vld && !lk_hit && lk_entry == '0 && lk_mtype == DEFAULT_MTYPE));
endmodule

bind memattr_region_unit memattr_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W), .DEFAULT_MTYPE(DEFAULT_MTYPE)
) chk_i (.*);

// File: tb/memattr_region_unit_tb_top.sv
module memattr_region_unit_tb_top;
  localparam int NE = 16;
  localparam int PA = 34;
  localparam logic [4:0] DEF_MT = 5'd0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  csr_bank = '0;
  logic [3:0]  csr_idx = '0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        lk_req = 1'b0;
  logic [PA-1:2] lk_addr = '0;
  logic        lk_vld, lk_hit;
  logic [3:0]  lk_entry;
  logic [4:0]  lk_mtype;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  logic [63:0] m_areg [NE];
  logic [6:0]  m_cfg  [NE];

  always #10 clk = ~clk;

  memattr_region_unit #(.NUM_ENTRIES(NE), .PA_W(PA), .DEFAULT_MTYPE(DEF_MT)) dut_i (
    .clk(clk), .rst(rst), .csr_bank(csr_bank), .csr_idx(csr_idx), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_entry(lk_entry), .lk_mtype(lk_mtype)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic csr_write(input logic [1:0] b, input int i, input logic [63:0] d);
    @(negedge clk);
    csr_bank = b; csr_idx = 4'(i); csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] b, input int i, output logic [63:0] d);
    @(negedge clk);
    csr_bank = b; csr_idx = 4'(i); csr_we = 1'b0;
    @(negedge clk);
    d = csr_rdata;
  endtask

  function automatic bit in_region(input logic [63:0] v, input longint unsigned a);
    int k = 0;
    longint unsigned base, size;
    while (k < 64 && v[k]) k++;
    if (k >= 58) return 1'b1;
    base = (v - ((64'd1 << k) - 1)) << 2;
    size = 64'd1 << (k + 3);
    return (a >= base) && (a < base + size);
  endfunction

  function automatic logic [9:0] model(input longint unsigned a);
    for (int e = 0; e < NE; e++) begin
      if (m_cfg[e][1:0] == 2'd3 && in_region(m_areg[e], a))
        return {1'b1, 4'(e), m_cfg[e][6:2]};
    end
    return {1'b0, 4'd0, DEF_MT};
  endfunction

  task automatic lookup(input longint unsigned a, input string tag);
    logic [9:0] exp;
    exp = model(a);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a[PA-1:2];
    @(negedge clk);
    lk_req = 1'b0;
    check(lk_vld === 1'b1, "R9 lk_vld after request", 64'(lk_vld), 64'd1);
    check({lk_hit, lk_entry, lk_mtype} === exp, tag, 64'({lk_hit, lk_entry, lk_mtype}), 64'(exp));
  endtask

  task automatic push_cfg();
    logic [63:0] w0, w2;
    w0 = '0; w2 = '0;
    for (int b = 0; b < 8; b++) begin
      w0[b*8 +: 8] = {1'b0, m_cfg[b]};
      w2[b*8 +: 8] = {1'b0, m_cfg[b+8]};
    end
    csr_write(2'd0, 0, w0);
    csr_write(2'd0, 2, w2);
  endtask

  task automatic set_entry(input int e, input longint unsigned base, input longint unsigned size,
                           input logic [1:0] et, input logic [4:0] mt);
    logic [63:0] rb;
    m_areg[e] = (base >> 2) + (size >> 3) - 1;
    m_cfg[e]  = {mt, et};
    csr_write(2'd1, e, m_areg[e]);
    csr_read(2'd1, e, rb);
    check(rb === m_areg[e], "R1 R4 encoded region read back", rb, m_areg[e]);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 256; i++)
      lookup((longint'(i) << 26) + longint'(i % 5) * 64'h1000, tag);
    for (int i = 0; i < 64; i++)
      lookup(longint'(i) * 64'h800, tag);
    for (int e = 0; e < NE; e++) begin
      if (m_cfg[e][1:0] != 2'd0) begin
        int k = 0;
        longint unsigned base, size;
        while (k < 40 && m_areg[e][k]) k++;
        base = (m_areg[e] - ((64'd1 << k) - 1)) << 2;
        size = 64'd1 << (k + 3);
        if (base > 0) lookup(base - 4, tag);
        lookup(base, tag);
        lookup(base + size / 2, tag);
        lookup(base + size - 4, tag);
        if (base + size < (64'd1 << PA)) lookup(base + size, tag);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired before the scenarios finished");
      report();
    end
  end

  initial begin
    logic [63:0] rd;
    for (int e = 0; e < NE; e++) begin m_areg[e] = '0; m_cfg[e] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(csr_rdata === '0 && lk_vld === 1'b0 && lk_hit === 1'b0 && lk_mtype === DEF_MT,
          "R11 outputs during reset", csr_rdata, 64'd0);
    rst = 1'b0;

    // R11: all registers cleared
    for (int i = 0; i < NE; i++) begin
      csr_read(2'd1, i, rd);
      check(rd === '0, "R11 address register after reset", rd, 64'd0);
      csr_read(2'd0, i, rd);
      check(rd === '0, "R11 configuration register after reset", rd, 64'd0);
    end
    lookup(64'h5800_0000, "R7 R11 lookup after reset");
    lookup(64'h0, "R7 R11 lookup after reset");

    // R1: full-width read-back of every address register
    for (int i = 0; i < NE; i++) begin
      logic [63:0] pat;
      pat = 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0123_4567_89AB_CDEF);
      csr_write(2'd1, i, pat);
    end
    for (int i = NE - 1; i >= 0; i--) begin
      logic [63:0] pat;
      pat = 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0123_4567_89AB_CDEF);
      csr_read(2'd1, i, rd);
      check(rd === pat, "R1 address register read-back", rd, pat);
    end

    // R3: bit 7 of each byte dropped, 7 bits kept
    csr_write(2'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_read(2'd0, 0, rd);
    check(rd === 64'h7F7F_7F7F_7F7F_7F7F, "R3 cfg index 0 bit7 cleared", rd, 64'h7F7F_7F7F_7F7F_7F7F);
    csr_write(2'd0, 2, 64'h8081_8283_8485_8687);
    csr_read(2'd0, 2, rd);
    check(rd === 64'h0001_0203_0405_0607, "R3 cfg index 2 bit7 cleared", rd, 64'h0001_0203_0405_0607);

    // R2: only indices 0 and 2 exist in bank 0
    for (int i = 0; i < NE; i++) begin
      if (i != 0 && i != 2) csr_write(2'd0, i, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    for (int i = 0; i < NE; i++) begin
      logic [63:0] exp;
      exp = (i == 0) ? 64'h7F7F_7F7F_7F7F_7F7F : (i == 2) ? 64'h0001_0203_0405_0607 : 64'd0;
      csr_read(2'd0, i, rd);
      check(rd === exp, "R2 cfg packing and holes", rd, exp);
    end

    // R10: feature and empty banks, writes ignored
    csr_write(2'd2, 0, 64'hDEAD_BEEF_DEAD_BEEF);
    csr_write(2'd3, 5, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < NE; i += 5) begin
      csr_read(2'd2, i, rd);
      check(rd === 64'h4000_0000, "R10 feature word", rd, 64'h4000_0000);
      csr_read(2'd3, i, rd);
      check(rd === '0, "R10 empty bank", rd, 64'd0);
    end
    csr_read(2'd1, 5, rd);
    check(rd === (64'hA5A5_0000_0000_0000 ^ (64'd5 * 64'h0123_4567_89AB_CDEF)),
          "R10 address register untouched by bank 3 write", rd,
          64'hA5A5_0000_0000_0000 ^ (64'd5 * 64'h0123_4567_89AB_CDEF));

    // R5: non-region entry types never match
    for (int e = 0; e < NE; e++) m_areg[e] = 64'hA5A5_0000_0000_0000 ^ (64'(e) * 64'h0123_4567_89AB_CDEF);
    for (int e = 0; e < NE; e++) m_cfg[e] = {5'd9, 2'(e % 3)};
    m_areg[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    csr_write(2'd1, 0, m_areg[0]);
    push_cfg();
    for (int i = 0; i < 32; i++) lookup(longint'(i) * 64'h1F00_0000, "R5 entry types 0 1 2 ignored");

    // R4 R6 R8: programmed regions
    for (int e = 0; e < NE; e++) begin
      m_cfg[e] = '0; m_areg[e] = '0;
      csr_write(2'd1, e, 64'd0);
    end
    set_entry(0,  64'h5800_0000,   64'h0800_0000,   2'd3, 5'd3);
    check(m_areg[0] === 64'h16FF_FFFF, "R4 encoding of 0x58000000/0x08000000", m_areg[0], 64'h16FF_FFFF);
    set_entry(1,  64'h5900_0000,   64'h1000,        2'd3, 5'd11);
    set_entry(2,  64'h1000,        64'h1000,        2'd3, 5'd8);
    set_entry(3,  64'h2000,        64'h1000,        2'd0, 5'd9);
    set_entry(4,  64'h4000,        64'h4000,        2'd1, 5'd10);
    set_entry(5,  64'h8000,        64'h8000,        2'd3, 5'd2);
    set_entry(7,  64'h1_0000,      64'h1_0000,      2'd3, 5'd5);
    set_entry(9,  64'h4000_0000,   64'h4000_0000,   2'd3, 5'd1);
    set_entry(12, 64'h1_0000_0000, 64'h1_0000_0000, 2'd3, 5'd9);
    set_entry(14, 64'h2000,        64'h1000,        2'd3, 5'd26);
    m_cfg[2][6] = 1'b1;
    m_cfg[14] = {5'd10, 2'd3};
    push_cfg();
    sweep("R4 R6 R8 region lookup");

    // R6: catch-all at the lowest priority
    set_entry(15, 64'h0, 64'h4_0000_0000, 2'd3, 5'd10);
    push_cfg();
    sweep("R6 R8 lookup with catch-all entry");

    // R6: removing the top entry exposes the next one
    m_cfg[0] = '0;
    push_cfg();
    lookup(64'h5900_0000, "R6 shadowed entry wins once entry 0 is off");
    lookup(64'h5800_0000, "R6 fallback to entry 9");
    sweep("R6 lookup without entry 0");

    // R9: valid falls without a request
    @(negedge clk);
    check(lk_vld === 1'b0, "R9 lk_vld low without request", 64'(lk_vld), 64'd0);

    done = 1;
    report();
  end
endmodule